// File: doc/BRIEF.md
# Dual-Channel Streaming DAC Output Controller

This block drives two 16-bit DAC data buses from a single 32-bit host write path. Every host word holds one sample for each channel: the low half goes to channel 0 and the high half goes to channel 1. Both buses take their new values on the same clock edge, so the two outputs never drift apart.

Host words normally go into a deep output FIFO. The FIFO hands one word to the outputs on each sample tick. The sample tick comes either from the acquisition sample-clock pulse or from a rising edge on an external clock pin. That pin is asynchronous, so the block synchronizes it before use. A control bit can bypass the FIFO. In bypass mode, host writes go straight to the output holding register, which suits slow static use such as setting a comparator threshold on channel 0.

An interrupt request stays high while the FIFO is less than half full, so the host knows when to refill it. If a sample tick finds the FIFO empty, the outputs keep their last value and a sticky underflow flag is set. A clear strobe empties the FIFO.

Top module: `dac_stream_ctrl`

## Requirements
- R1: After reset, both DAC buses read 16'h8000 (offset-binary midscale), `irq_refill` is 1 and `underflow` is 0.
- R2: A word taken by the outputs drives bits 15:0 onto `dac0_data` and bits 31:16 onto `dac1_data`, and both buses change on the same clock edge.
- R3: In streaming mode (control bit 0 = 0), words leave the FIFO in the order they were written, one word per sample tick. The outputs change on the clock edge that samples the tick and at no other time.
- R4: Control bit 1 picks the tick source. With bit 1 = 0, an `acq_tick` pulse is the tick and `ext_clk` has no effect. With bit 1 = 1, a rising edge of `ext_clk` is the tick and `acq_tick` has no effect. In that case the outputs update on the third `clk` edge after the rising edge is first sampled.
- R5: With control bit 0 = 1 (bypass), a `data_wr` word appears on the outputs after the next clock edge. In bypass mode, sample ticks do not change the outputs, and bypass writes do not enter the FIFO.
- R6: `irq_refill` is 1 exactly while the FIFO holds fewer than DEPTH/2 words.
- R7: A sample tick in streaming mode with an empty FIFO leaves the outputs unchanged and sets `underflow`. The flag stays set until `fifo_clr` or reset.
- R8: `fifo_clr` empties the FIFO and clears `underflow`, and leaves the DAC buses unchanged.
- R9: A streaming write when the FIFO already holds DEPTH words is discarded.
- R10: `ctrl_wr` loads control bits 1:0 from `wdata[1:0]`. A `data_wr` in the same cycle uses the previous mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| data_wr | input | 1 | Host data write strobe |
| ctrl_wr | input | 1 | Host control write strobe (bit 0 bypass, bit 1 external tick) |
| fifo_clr | input | 1 | FIFO clear strobe |
| wdata | input | 32 | Host write data |
| acq_tick | input | 1 | Acquisition sample-clock pulse, one cycle per sample |
| ext_clk | input | 1 | External sample clock, asynchronous |
| dac0_data | output | 16 | Channel 0 DAC code |
| dac1_data | output | 16 | Channel 1 DAC code |
| irq_refill | output | 1 | FIFO less than half full |
| underflow | output | 1 | Sticky: a tick found the FIFO empty |

## Verification
The bound checker checks these on every cycle:
- the outputs move only on a tick in streaming mode, or on a bypass write;
- a bypass write lands on the outputs one edge later;
- the FIFO level never exceeds its depth;
- underflow stays set until cleared, and the outputs hold when it rises;
- a clear leaves the request high and the flag low.

Only the bench scenarios can show the following:
- that words come out in write order;
- the exact three-edge latency of the external clock path;
- that the unselected tick source is ignored;
- that writes to a full FIFO are discarded;
- the exact half-full boundary of the interrupt.

// File: rtl/dac_pkg.sv
package dac_pkg;
  typedef struct packed {
    logic ext_sel;
    logic bypass;
  } dac_ctrl_t;
endpackage

// File: rtl/dac_tick_sel.sv
module dac_tick_sel #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_sel,
  input  logic acq_tick,
  input  logic ext_clk,
  output logic tick
);
  // one stage past the synchronizer for edge detection
  logic [SYNC_STAGES:0] sync_q;
  logic [SYNC_STAGES:0] sync_d;
  logic                 ext_rise;

  always_comb begin
    sync_d = {sync_q[SYNC_STAGES-1:0], ext_clk};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign ext_rise = sync_q[SYNC_STAGES-1] & ~sync_q[SYNC_STAGES];
  assign tick     = ext_sel ? ext_rise : acq_tick;
endmodule

// File: rtl/dac_fifo.sv
module dac_fifo #(
  parameter int WORD_W = 32,
  parameter int AW     = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              push,
  input  logic              pop,
  input  logic [WORD_W-1:0] din,
  output logic [WORD_W-1:0] dout,
  output logic [AW:0]       count,
  output logic              empty,
  output logic              full
);
  localparam int DEPTH = 1 << AW;

  logic [WORD_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_ptr_q, wr_ptr_d;
  logic [AW-1:0]     rd_ptr_q, rd_ptr_d;
  logic [AW:0]       count_q, count_d;
  logic              do_push, do_pop;

  assign empty   = (count_q == '0);
  assign full    = (count_q == (AW+1)'(DEPTH));
  assign do_push = push & ~full;
  assign do_pop  = pop & ~empty;

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    count_d  = count_q;
    if (clr) begin
      wr_ptr_d = '0;
      rd_ptr_d = '0;
      count_d  = '0;
    end else begin
      if (do_push) wr_ptr_d = wr_ptr_q + 1'b1;
      if (do_pop)  rd_ptr_d = rd_ptr_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count_d = count_q + 1'b1;
        2'b01:   count_d = count_q - 1'b1;
        default: count_d = count_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      count_q  <= count_d;
    end
  end

  // storage array carries no reset
  always_ff @(posedge clk) begin
    if (do_push && !clr) mem[wr_ptr_q] <= din;
  end

  assign dout  = mem[rd_ptr_q];
  assign count = count_q;
endmodule

// File: rtl/dac_out_reg.sv
module dac_out_reg #(
  parameter int          WORD_W    = 32,
  parameter logic [31:0] RESET_VAL = 32'h8000_8000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bypass,
  input  logic              host_wr,
  input  logic [WORD_W-1:0] host_word,
  input  logic              tick,
  input  logic              fifo_empty,
  input  logic [WORD_W-1:0] fifo_word,
  input  logic              clr,
  output logic              pop,
  output logic [WORD_W-1:0] out_word,
  output logic              underflow
);
  logic [WORD_W-1:0] out_q, out_d;
  logic              uf_q, uf_d;
  logic              out_en;

  assign pop = tick & ~bypass & ~fifo_empty;

  always_comb begin
    out_en = 1'b0;
    out_d  = out_q;
    uf_d   = uf_q;
    if (bypass) begin
      if (host_wr) begin
        out_en = 1'b1;
        out_d  = host_word;
      end
    end else if (tick) begin
      if (!fifo_empty) begin
        out_en = 1'b1;
        out_d  = fifo_word;
      end else begin
        uf_d = 1'b1;
      end
    end
    if (clr) uf_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= RESET_VAL[WORD_W-1:0];
      uf_q  <= 1'b0;
    end else begin
      if (out_en) out_q <= out_d;
      uf_q <= uf_d;
    end
  end

  assign out_word  = out_q;
  assign underflow = uf_q;
endmodule

// File: rtl/dac_stream_ctrl.sv
module dac_stream_ctrl #(
  parameter int CH_W        = 16,
  parameter int FIFO_AW     = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              data_wr,
  input  logic              ctrl_wr,
  input  logic              fifo_clr,
  input  logic [2*CH_W-1:0] wdata,
  input  logic              acq_tick,
  input  logic              ext_clk,
  output logic [CH_W-1:0]   dac0_data,
  output logic [CH_W-1:0]   dac1_data,
  output logic              irq_refill,
  output logic              underflow
);
  import dac_pkg::*;

  localparam int WORD_W = 2 * CH_W;
  localparam int DEPTH  = 1 << FIFO_AW;
  localparam int HALF   = DEPTH / 2;
  localparam logic [CH_W-1:0]   MID_CODE  = {1'b1, {(CH_W-1){1'b0}}};
  localparam logic [WORD_W-1:0] MID_WORD  = {MID_CODE, MID_CODE};

  dac_ctrl_t         ctrl_q, ctrl_d;
  logic              sample_tick;
  logic              fifo_push, fifo_pop, fifo_empty, fifo_full;
  logic [WORD_W-1:0] fifo_word, out_word;
  logic [FIFO_AW:0]  fifo_count;

  always_comb begin
    ctrl_d = ctrl_q;
    if (ctrl_wr) ctrl_d = dac_ctrl_t'(wdata[1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end

  dac_tick_sel #(.SYNC_STAGES(SYNC_STAGES)) u_tick (
    .clk      (clk),
    .rst_n    (rst_n),
    .ext_sel  (ctrl_q.ext_sel),
    .acq_tick (acq_tick),
    .ext_clk  (ext_clk),
    .tick     (sample_tick)
  );

  assign fifo_push = data_wr & ~ctrl_q.bypass;

  dac_fifo #(.WORD_W(WORD_W), .AW(FIFO_AW)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (fifo_clr),
    .push  (fifo_push),
    .pop   (fifo_pop),
    .din   (wdata),
    .dout  (fifo_word),
    .count (fifo_count),
    .empty (fifo_empty),
    .full  (fifo_full)
  );

  dac_out_reg #(.WORD_W(WORD_W), .RESET_VAL(32'(MID_WORD))) u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .bypass     (ctrl_q.bypass),
    .host_wr    (data_wr),
    .host_word  (wdata),
    .tick       (sample_tick),
    .fifo_empty (fifo_empty),
    .fifo_word  (fifo_word),
    .clr        (fifo_clr),
    .pop        (fifo_pop),
    .out_word   (out_word),
    .underflow  (underflow)
  );

  assign dac0_data  = out_word[CH_W-1:0];
  assign dac1_data  = out_word[WORD_W-1:CH_W];
  assign irq_refill = (fifo_count < (FIFO_AW+1)'(HALF));
endmodule

// File: rtl/dac_stream_ctrl_chk.sv
module dac_stream_ctrl_chk #(
  parameter int CH_W    = 16,
  parameter int FIFO_AW = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              data_wr,
  input logic              fifo_clr,
  input logic [2*CH_W-1:0] wdata,
  input logic [CH_W-1:0]   dac0_data,
  input logic [CH_W-1:0]   dac1_data,
  input logic              irq_refill,
  input logic              underflow,
  input logic              bypass,
  input logic              tick,
  input logic [FIFO_AW:0]  level
);
  localparam int DEPTH = 1 << FIFO_AW;

  // R2 R3: outside bypass, outputs move only on a tick
  a_r3_no_move_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!bypass && !tick) |=> $stable({dac1_data, dac0_data}));

  // R5: bypass write shows up after one edge
  a_r5_bypass_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bypass && data_wr) |=> ({dac1_data, dac0_data} == $past(wdata)));

  // R5: bypass ignores ticks
  a_r5_bypass_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (bypass && !data_wr) |=> $stable({dac1_data, dac0_data}));

  // R7: outputs hold when underflow appears
  a_r7_hold_on_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(underflow) |-> $stable({dac1_data, dac0_data}));

  // R7: flag is sticky
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (underflow && !fifo_clr) |=> underflow);

  // R8: clear empties and drops the flag
  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_clr |=> (irq_refill && !underflow));

  // R9: level never exceeds depth
  a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    level <= (FIFO_AW+1)'(DEPTH));
endmodule

bind dac_stream_ctrl dac_stream_ctrl_chk #(.CH_W(CH_W), .FIFO_AW(FIFO_AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .data_wr    (data_wr),
  .fifo_clr   (fifo_clr),
  .wdata      (wdata),
  .dac0_data  (dac0_data),
  .dac1_data  (dac1_data),
  .irq_refill (irq_refill),
  .underflow  (underflow),
  .bypass     (ctrl_q.bypass),
  .tick       (sample_tick),
  .level      (fifo_count)
);

// File: tb/tb_dac_stream_ctrl.sv
module tb_dac_stream_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 4096;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        data_wr, ctrl_wr, fifo_clr, acq_tick, ext_clk;
  logic [31:0] wdata;
  logic [15:0] dac0_data, dac1_data;
  logic        irq_refill, underflow;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [31:0] q[$];
  logic [31:0] exp_out;
  logic        exp_uf;
  logic        m_byp, m_ext;

  always #(CLK_PERIOD/2) clk = ~clk;

  dac_stream_ctrl dut (
    .clk(clk), .rst_n(rst_n), .data_wr(data_wr), .ctrl_wr(ctrl_wr),
    .fifo_clr(fifo_clr), .wdata(wdata), .acq_tick(acq_tick), .ext_clk(ext_clk),
    .dac0_data(dac0_data), .dac1_data(dac1_data),
    .irq_refill(irq_refill), .underflow(underflow)
  );

  function automatic logic exp_irq();
    return (q.size() < DEPTH/2);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic chk_all(input string tag);
    chk({tag, " outputs"}, {dac1_data, dac0_data}, exp_out);
    chk({tag, " irq"}, 32'(irq_refill), 32'(exp_irq()));
    chk({tag, " underflow"}, 32'(underflow), 32'(exp_uf));
  endtask

  task automatic do_write(input logic [31:0] w);
    data_wr = 1'b1; wdata = w;
    @(negedge clk);
    data_wr = 1'b0;
    if (m_byp) exp_out = w;
    else if (q.size() < DEPTH) q.push_back(w);
  endtask

  task automatic do_ctrl(input logic byp, input logic ext);
    ctrl_wr = 1'b1; wdata = {30'd0, ext, byp};
    @(negedge clk);
    ctrl_wr = 1'b0;
    m_byp = byp; m_ext = ext;
  endtask

  task automatic model_tick();
    if (!m_byp) begin
      if (q.size() > 0) exp_out = q.pop_front();
      else exp_uf = 1'b1;
    end
  endtask

  task automatic do_acq();
    acq_tick = 1'b1;
    @(negedge clk);
    acq_tick = 1'b0;
    if (!m_ext) model_tick();
  endtask

  task automatic do_ext();
    ext_clk = 1'b1;
    repeat (4) @(negedge clk);
    ext_clk = 1'b0;
    repeat (3) @(negedge clk);
    if (m_ext) model_tick();
  endtask

  task automatic do_clr();
    fifo_clr = 1'b1;
    @(negedge clk);
    fifo_clr = 1'b0;
    q.delete();
    exp_uf = 1'b0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog act=hung exp=finished");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd5150));
    rst_n = 1'b0; data_wr = 0; ctrl_wr = 0; fifo_clr = 0; acq_tick = 0;
    ext_clk = 0; wdata = '0;
    exp_out = 32'h8000_8000; exp_uf = 1'b0; m_byp = 0; m_ext = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_all("R1 reset");

    // R7 underflow on empty FIFO
    do_acq();
    chk_all("R7 empty tick");
    do_acq();
    chk_all("R7 sticky");
    do_clr();
    chk_all("R8 clear uf");

    // R2 R3 packing and order
    do_write(32'hA1B2_C3D4);
    do_write(32'h0001_FFFE);
    do_write(32'h7FFF_8001);
    chk_all("R3 after writes");
    for (int i = 0; i < 3; i++) begin
      do_acq();
      chk({"R2 dac0"}, 32'(dac0_data), 32'(exp_out[15:0]));
      chk({"R2 dac1"}, 32'(dac1_data), 32'(exp_out[31:16]));
      chk_all("R3 stream");
    end

    // R4 external tick source, exact latency
    do_ctrl(1'b0, 1'b1);
    do_write(32'h1111_2222);
    do_write(32'h3333_4444);
    do_acq();
    chk_all("R4 acq ignored");
    ext_clk = 1'b1;
    repeat (2) @(negedge clk);
    chk({"R4 before 3rd edge"}, {dac1_data, dac0_data}, exp_out);
    @(negedge clk);
    model_tick();
    chk({"R4 at 3rd edge"}, {dac1_data, dac0_data}, exp_out);
    @(negedge clk);
    ext_clk = 1'b0;
    repeat (3) @(negedge clk);
    chk_all("R4 one pop per edge");

    // R10 ctrl back to internal: ext ignored
    do_ctrl(1'b0, 1'b0);
    do_ext();
    chk_all("R4 ext ignored");

    // R5 bypass
    do_ctrl(1'b1, 1'b0);
    do_write(32'hDEAD_BEEF);
    chk_all("R5 bypass write");
    do_acq();
    chk_all("R5 tick ignored");
    do_ctrl(1'b0, 1'b0);
    do_acq();
    chk_all("R5 FIFO untouched");
    do_acq();
    chk_all("R7 after bypass drain");

    // R6 R9 level boundaries
    do_clr();
    for (int i = 0; i < DEPTH/2 - 1; i++) do_write(32'(i) ^ 32'h5A5A_0000);
    chk_all("R6 below half");
    do_write(32'hCAFE_0001);
    chk_all("R6 at half");
    for (int i = 0; i < DEPTH/2; i++) do_write(32'(i) + 32'h0100_0000);
    do_write(32'hBAD0_BAD0);
    chk_all("R9 full");
    for (int i = 0; i < DEPTH; i++) begin
      do_acq();
      chk("R9 drain order", {dac1_data, dac0_data}, exp_out);
    end
    chk_all("R9 extra dropped");
    do_acq();
    chk_all("R7 after full drain");

    // R8 clear keeps outputs
    do_clr();
    do_write(32'h1234_5678);
    do_write(32'h9ABC_DEF0);
    do_clr();
    chk_all("R8 clear");
    do_acq();
    chk_all("R8 empty after clear");
    do_clr();

    // random mix
    for (int i = 0; i < 400; i++) begin
      int unsigned op;
      op = $urandom % 16;
      if (op < 7) do_write($urandom);
      else if (op < 14) do_acq();
      else if (op == 14) do_clr();
      else do_ext();
      chk_all("R3 random");
    end

    done = 1;
    summary();
    $finish;
  end
endmodule